// File: doc/BRIEF.md
# Floating-Point Operation Decoder and Register Mapper

This block sits on the path that handles floating-point operations trapped for completion. It takes one 32-bit instruction word, the trap-type field held in the current floating-point status, and a flag saying whether the operation arrived through the illegal-instruction path. It returns one registered result. The result says whether the word is a floating-point operation the block handles, and which precision each operand has. It also gives the 6-bit physical register index of each operand and the trap type the operation expects. Finally it gives the verdict: accepted, rejected for a trap-type mismatch, or rejected for a misaligned quad register.

On acceptance the block reports the new value of the status trap-type field. It also reports which half of the 64-entry register file the destination dirties. The arithmetic itself is done elsewhere.

Top module: `fp_opdec`

## Requirements
- R1: `out_valid` is high exactly one clock after a cycle with `in_valid` high, and low otherwise. Reset clears `out_valid`, `out_accept`, `out_mismatch`, `out_bad_reg` and both dirty outputs.
- R2: A word is handled when bits 31:30 are 2'b10 and bits 24:19 are 6'h34 (first group) or 6'h35 (second group). For any other word `out_fpop`, `out_unimpl`, `out_accept` and `out_mismatch` are 0, and `out_ftt_next` equals `in_ftt`.
- R3: The operation code is bits 13:5. Destination, source-1 and source-2 fields are bits 29:25, 18:14 and 4:0. Sizes are encoded 0 none, 1 single, 2 double, 3 quad. Quad operations report expected trap type 3, for example add 0x043 with all three operands quad and square root 0x02B. Single and double arithmetic reports 2, for example 0x041 single add and 0x042 double add.
- R4: For single and double square root (0x029, 0x02A in the first group), the expected trap type equals `in_ftt`.
- R5: A single operand's index is {1'b0, field}. A double or quad operand's index is {field[0], field[4:1], 1'b0}. An operand of size none gives index 0.
- R6: A quad operand whose field has bit 1 set raises `out_bad_reg`, sets `out_ftt_next` to 6 and blocks acceptance.
- R7: When `in_illegal_path` is 0 and the expected trap type differs from `in_ftt`, `out_mismatch` is raised and `out_ftt_next` keeps `in_ftt`. This check comes before the register check, and it is skipped when `in_illegal_path` is 1.
- R8: An accepted operation sets `out_ftt_next` to 0.
- R9: A handled word with an operation code outside the supported set raises `out_unimpl`, reports all sizes as none and never accepts.
- R10: Compares (0x053, 0x057 in the second group) have no destination, take quad source-1 and source-2 operands and expect trap type 3.
- R11: On acceptance with a destination, `out_lo_dirty` is set when the destination index is below 32 and `out_hi_dirty` when it is 32 or above. Without acceptance neither is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Instruction word present |
| in_insn | input | 32 | Instruction word |
| in_ftt | input | 3 | Current status trap-type field |
| in_illegal_path | input | 1 | Operation came via illegal-instruction path |
| out_valid | output | 1 | Result valid |
| out_fpop | output | 1 | Word is a handled floating-point operation |
| out_unimpl | output | 1 | Operation code not supported |
| out_exp_ftt | output | 3 | Expected trap type |
| out_rd_sz | output | 2 | Destination size |
| out_rs1_sz | output | 2 | Source-1 size |
| out_rs2_sz | output | 2 | Source-2 size |
| out_rd_idx | output | 6 | Destination physical index |
| out_rs1_idx | output | 6 | Source-1 physical index |
| out_rs2_idx | output | 6 | Source-2 physical index |
| out_bad_reg | output | 1 | Misaligned quad register |
| out_mismatch | output | 1 | Trap type mismatch |
| out_accept | output | 1 | Operation accepted |
| out_ftt_next | output | 3 | New status trap-type field |
| out_lo_dirty | output | 1 | Lower register half written |
| out_hi_dirty | output | 1 | Upper register half written |

## Verification
The hardest case to reach is the misaligned quad register. It only shows when the opcode is a supported quad form, the trap type matches (or the illegal path is set) and the offending field has bit 1 set. A purely random word almost never gets all three at once. The stimulus therefore draws operation codes from the supported list and usually sets `in_ftt` to the expected value. Directed cases then pin down a mismatch that masks a bad register, and square root following the live trap-type field.

// File: rtl/fp_opdec.sv
module fp_opdec (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_insn,
  input  logic [2:0]  in_ftt,
  input  logic        in_illegal_path,
  output logic        out_valid,
  output logic        out_fpop,
  output logic        out_unimpl,
  output logic [2:0]  out_exp_ftt,
  output logic [1:0]  out_rd_sz,
  output logic [1:0]  out_rs1_sz,
  output logic [1:0]  out_rs2_sz,
  output logic [5:0]  out_rd_idx,
  output logic [5:0]  out_rs1_idx,
  output logic [5:0]  out_rs2_idx,
  output logic        out_bad_reg,
  output logic        out_mismatch,
  output logic        out_accept,
  output logic [2:0]  out_ftt_next,
  output logic        out_lo_dirty,
  output logic        out_hi_dirty
);
  localparam logic [1:0] N = 2'd0, S = 2'd1, D = 2'd2, Q = 2'd3;

  logic       grp1, grp2, fpop, known, live_ftt;
  logic [8:0] opf;
  logic [4:0] f_rd, f_rs1, f_rs2;
  logic [1:0] sz_rd, sz_rs1, sz_rs2;
  logic [2:0] fix_ftt, exp_ftt, ftt_next;
  logic [5:0] i_rd, i_rs1, i_rs2;
  logic       mism, bad, acc;

  assign grp1 = {in_insn[31:30], in_insn[24:19]} == 8'b10_110100;
  assign grp2 = {in_insn[31:30], in_insn[24:19]} == 8'b10_110101;
  assign fpop = grp1 | grp2;
  assign opf  = in_insn[13:5];
  assign f_rd  = in_insn[29:25];
  assign f_rs1 = in_insn[18:14];
  assign f_rs2 = in_insn[4:0];

  always_comb begin
    {known, live_ftt, sz_rd, sz_rs2, sz_rs1, fix_ftt} = {1'b0, 1'b0, N, N, N, 3'd0};
    if (grp2) begin
      if (opf == 9'h053 || opf == 9'h057) {known, sz_rd, sz_rs2, sz_rs1, fix_ftt} = {1'b1, N, Q, Q, 3'd3};
    end else if (grp1) begin
      known = 1'b1;
      case (opf)
        9'h003, 9'h007, 9'h00b, 9'h02b:         {sz_rd, sz_rs2, sz_rs1, fix_ftt} = {Q, Q, N, 3'd3};
        9'h043, 9'h047, 9'h04b, 9'h04f:         {sz_rd, sz_rs2, sz_rs1, fix_ftt} = {Q, Q, Q, 3'd3};
        9'h06e:                                 {sz_rd, sz_rs2, sz_rs1, fix_ftt} = {Q, D, D, 3'd3};
        9'h083, 9'h0cb:                         {sz_rd, sz_rs2, sz_rs1, fix_ftt} = {D, Q, N, 3'd3};
        9'h08c, 9'h0ce:                         {sz_rd, sz_rs2, sz_rs1, fix_ftt} = {Q, D, N, 3'd3};
        9'h0c7, 9'h0d3:                         {sz_rd, sz_rs2, sz_rs1, fix_ftt} = {S, Q, N, 3'd3};
        9'h0cc, 9'h0cd:                         {sz_rd, sz_rs2, sz_rs1, fix_ftt} = {Q, S, N, 3'd3};
        9'h029: begin {sz_rd, sz_rs2, sz_rs1} = {S, S, N}; live_ftt = 1'b1; end
        9'h02a: begin {sz_rd, sz_rs2, sz_rs1} = {D, D, N}; live_ftt = 1'b1; end
        9'h042, 9'h046, 9'h04a, 9'h04e:         {sz_rd, sz_rs2, sz_rs1, fix_ftt} = {D, D, D, 3'd2};
        9'h041, 9'h045, 9'h049, 9'h04d:         {sz_rd, sz_rs2, sz_rs1, fix_ftt} = {S, S, S, 3'd2};
        9'h069:                                 {sz_rd, sz_rs2, sz_rs1, fix_ftt} = {D, S, S, 3'd2};
        9'h081, 9'h0c9, 9'h0c8:                 {sz_rd, sz_rs2, sz_rs1, fix_ftt} = {D, S, N, 3'd2};
        9'h082, 9'h088:                         {sz_rd, sz_rs2, sz_rs1, fix_ftt} = {D, D, N, 3'd2};
        9'h0c6, 9'h0d2, 9'h084:                 {sz_rd, sz_rs2, sz_rs1, fix_ftt} = {S, D, N, 3'd2};
        9'h0d1:                                 {sz_rd, sz_rs2, sz_rs1, fix_ftt} = {S, S, N, 3'd2};
        default: known = 1'b0;
      endcase
    end
  end

  function automatic logic [5:0] map_idx(input logic [4:0] f, input logic [1:0] sz);
    if (sz == N)      return 6'd0;
    else if (sz == S) return {1'b0, f};
    else              return {f[0], f[4:1], 1'b0};
  endfunction

  assign i_rd  = map_idx(f_rd,  sz_rd);
  assign i_rs1 = map_idx(f_rs1, sz_rs1);
  assign i_rs2 = map_idx(f_rs2, sz_rs2);

  assign exp_ftt = !known ? 3'd0 : (live_ftt ? in_ftt : fix_ftt);
  assign mism = known && !in_illegal_path && (exp_ftt != in_ftt);
  assign bad  = known && !mism && ((sz_rd == Q && f_rd[1]) || (sz_rs1 == Q && f_rs1[1]) || (sz_rs2 == Q && f_rs2[1]));
  assign acc  = known && !mism && !bad;
  assign ftt_next = bad ? 3'd6 : (acc ? 3'd0 : in_ftt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      {out_accept, out_mismatch, out_bad_reg, out_lo_dirty, out_hi_dirty} <= '0;
    end else begin
      out_valid    <= in_valid;
      out_accept   <= in_valid && acc;
      out_mismatch <= in_valid && mism;
      out_bad_reg  <= in_valid && bad;
      out_lo_dirty <= in_valid && acc && sz_rd != N && !i_rd[5];
      out_hi_dirty <= in_valid && acc && sz_rd != N && i_rd[5];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {out_fpop, out_unimpl, out_exp_ftt, out_ftt_next} <= '0;
      {out_rd_sz, out_rs1_sz, out_rs2_sz} <= '0;
      {out_rd_idx, out_rs1_idx, out_rs2_idx} <= '0;
    end else if (in_valid) begin
      out_fpop     <= fpop;
      out_unimpl   <= fpop && !known;
      out_exp_ftt  <= exp_ftt;
      out_ftt_next <= ftt_next;
      {out_rd_sz, out_rs1_sz, out_rs2_sz} <= {sz_rd, sz_rs1, sz_rs2};
      {out_rd_idx, out_rs1_idx, out_rs2_idx} <= {i_rd, i_rs1, i_rs2};
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));
  a_r7_mismatch_keeps_ftt: assert property (@(posedge clk) disable iff (!rst_n)
    out_mismatch |-> (out_ftt_next == $past(in_ftt)) && !out_accept && !out_bad_reg);
  a_r8_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
    out_accept |-> out_ftt_next == 3'd0 && out_fpop && !out_unimpl);
  a_r6_bad_reg_six: assert property (@(posedge clk) disable iff (!rst_n)
    out_bad_reg |-> out_ftt_next == 3'd6 && !out_accept);
  a_r9_unimpl_none: assert property (@(posedge clk) disable iff (!rst_n)
    out_unimpl |-> !out_accept && out_rd_sz == 2'd0 && out_rs1_sz == 2'd0 && out_rs2_sz == 2'd0);
  a_r11_dirty_one_half: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_lo_dirty, out_hi_dirty}) && ((out_lo_dirty || out_hi_dirty) -> out_accept));
endmodule

// File: tb/fp_opdec_tb.sv
module fp_opdec_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_illegal_path = 1'b0;
  logic [31:0] in_insn = '0;
  logic [2:0]  in_ftt = '0;
  logic out_valid, out_fpop, out_unimpl, out_bad_reg, out_mismatch, out_accept, out_lo_dirty, out_hi_dirty;
  logic [2:0] out_exp_ftt, out_ftt_next;
  logic [1:0] out_rd_sz, out_rs1_sz, out_rs2_sz;
  logic [5:0] out_rd_idx, out_rs1_idx, out_rs2_idx;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fp_opdec u_dut (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h insn=%h", req, act, exp, in_insn);
    end
  endtask

  // reference class: {known, live, rd, rs2, rs1, ftt}
  function automatic logic [10:0] ref_cls(input bit g2, input logic [8:0] op);
    if (g2) return (op == 9'h053 || op == 9'h057) ? {2'b10, 2'd0, 2'd3, 2'd3, 3'd3} : 11'd0;
    case (op)
      9'h003, 9'h007, 9'h00b, 9'h02b: return {2'b10, 2'd3, 2'd3, 2'd0, 3'd3};
      9'h043, 9'h047, 9'h04b, 9'h04f: return {2'b10, 2'd3, 2'd3, 2'd3, 3'd3};
      9'h06e: return {2'b10, 2'd3, 2'd2, 2'd2, 3'd3};
      9'h083: return {2'b10, 2'd2, 2'd3, 2'd0, 3'd3};
      9'h08c: return {2'b10, 2'd3, 2'd2, 2'd0, 3'd3};
      9'h0c7: return {2'b10, 2'd1, 2'd3, 2'd0, 3'd3};
      9'h0cb: return {2'b10, 2'd2, 2'd3, 2'd0, 3'd3};
      9'h0cc: return {2'b10, 2'd3, 2'd1, 2'd0, 3'd3};
      9'h0cd: return {2'b10, 2'd3, 2'd1, 2'd0, 3'd3};
      9'h0ce: return {2'b10, 2'd3, 2'd2, 2'd0, 3'd3};
      9'h0d3: return {2'b10, 2'd1, 2'd3, 2'd0, 3'd3};
      9'h029: return {2'b11, 2'd1, 2'd1, 2'd0, 3'd0};
      9'h02a: return {2'b11, 2'd2, 2'd2, 2'd0, 3'd0};
      9'h041, 9'h045, 9'h049, 9'h04d: return {2'b10, 2'd1, 2'd1, 2'd1, 3'd2};
      9'h042, 9'h046, 9'h04a, 9'h04e: return {2'b10, 2'd2, 2'd2, 2'd2, 3'd2};
      9'h069: return {2'b10, 2'd2, 2'd1, 2'd1, 3'd2};
      9'h081: return {2'b10, 2'd2, 2'd1, 2'd0, 3'd2};
      9'h082: return {2'b10, 2'd2, 2'd2, 2'd0, 3'd2};
      9'h0c6: return {2'b10, 2'd1, 2'd2, 2'd0, 3'd2};
      9'h0c9: return {2'b10, 2'd2, 2'd1, 2'd0, 3'd2};
      9'h0d1: return {2'b10, 2'd1, 2'd1, 2'd0, 3'd2};
      9'h0d2: return {2'b10, 2'd1, 2'd2, 2'd0, 3'd2};
      9'h084: return {2'b10, 2'd1, 2'd2, 2'd0, 3'd2};
      9'h088: return {2'b10, 2'd2, 2'd2, 2'd0, 3'd2};
      9'h0c8: return {2'b10, 2'd2, 2'd1, 2'd0, 3'd2};
      default: return 11'd0;
    endcase
  endfunction

  function automatic logic [5:0] ref_idx(input logic [4:0] f, input logic [1:0] sz);
    case (sz)
      2'd0: return 6'd0;
      2'd1: return {1'b0, f};
      default: return {f[0], f[4:1], 1'b0};
    endcase
  endfunction

  function automatic logic [31:0] mk(input bit g2, input logic [8:0] op, input logic [4:0] rd, input logic [4:0] r1, input logic [4:0] r2);
    return {2'b10, rd, (g2 ? 6'h35 : 6'h34), r1, op, r2};
  endfunction

  task automatic apply_and_check(input logic [31:0] w, input logic [2:0] ftt, input bit ill);
    bit g1, g2, fp, known, mism, bad, acc;
    logic [10:0] c;
    logic [1:0] srd, s1, s2;
    logic [2:0] eft, nxt;
    logic [5:0] ird;
    @(negedge clk);
    in_valid = 1'b1; in_insn = w; in_ftt = ftt; in_illegal_path = ill;
    g1 = w[31:30] == 2'b10 && w[24:19] == 6'h34;
    g2 = w[31:30] == 2'b10 && w[24:19] == 6'h35;
    fp = g1 || g2;
    c = fp ? ref_cls(g2, w[13:5]) : 11'd0;
    known = c[10];
    srd = c[8:7]; s2 = c[6:5]; s1 = c[4:3];
    eft = !known ? 3'd0 : (c[9] ? ftt : c[2:0]);
    mism = known && !ill && eft != ftt;
    bad = known && !mism && ((srd == 3 && w[26]) || (s1 == 3 && w[15]) || (s2 == 3 && w[1]));
    acc = known && !mism && !bad;
    nxt = bad ? 3'd6 : (acc ? 3'd0 : ftt);
    ird = ref_idx(w[29:25], srd);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R1 valid", out_valid, 1);
    check(out_fpop == fp, "R2 recognised", out_fpop, fp);
    check({out_rd_sz, out_rs1_sz, out_rs2_sz} == {srd, s1, s2}, "R3 R10 sizes", {out_rd_sz, out_rs1_sz, out_rs2_sz}, {srd, s1, s2});
    check(out_exp_ftt == eft, "R3 R4 expected ftt", out_exp_ftt, eft);
    check({out_rd_idx, out_rs1_idx, out_rs2_idx} == {ird, ref_idx(w[18:14], s1), ref_idx(w[4:0], s2)}, "R5 index",
          {out_rd_idx, out_rs1_idx, out_rs2_idx}, {ird, ref_idx(w[18:14], s1), ref_idx(w[4:0], s2)});
    check(out_unimpl == (fp && !known), "R9 unimpl", out_unimpl, fp && !known);
    check({out_mismatch, out_bad_reg, out_accept} == {mism, bad, acc}, "R6 R7 R8 verdict", {out_mismatch, out_bad_reg, out_accept}, {mism, bad, acc});
    check(out_ftt_next == nxt, "R6 R7 R8 ftt next", out_ftt_next, nxt);
    check({out_lo_dirty, out_hi_dirty} == {acc && srd != 0 && !ird[5], acc && srd != 0 && ird[5]}, "R11 dirty",
          {out_lo_dirty, out_hi_dirty}, {acc && srd != 0 && !ird[5], acc && srd != 0 && ird[5]});
  endtask

  logic [8:0] ops [30] = '{9'h003, 9'h007, 9'h00b, 9'h02b, 9'h043, 9'h047, 9'h04b, 9'h04f, 9'h06e, 9'h083,
                           9'h08c, 9'h0c7, 9'h0cb, 9'h0cc, 9'h0cd, 9'h0ce, 9'h0d3, 9'h029, 9'h02a, 9'h041,
                           9'h042, 9'h046, 9'h049, 9'h04e, 9'h069, 9'h081, 9'h082, 9'h0c6, 9'h0d2, 9'h053};

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 0 && out_accept == 0 && out_lo_dirty == 0 && out_hi_dirty == 0 && out_bad_reg == 0 && out_mismatch == 0,
          "R1 reset", {out_valid, out_accept, out_lo_dirty, out_hi_dirty, out_bad_reg, out_mismatch}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 0, "R1 idle", out_valid, 0);
    // directed
    apply_and_check(mk(0, 9'h043, 5'd4, 5'd8, 5'd12), 3'd3, 0);      // R3 quad add accepted
    apply_and_check(mk(0, 9'h043, 5'd6, 5'd8, 5'd12), 3'd3, 0);      // R6 bad quad rd
    apply_and_check(mk(0, 9'h043, 5'd6, 5'd8, 5'd12), 3'd2, 0);      // R7 mismatch masks bad reg
    apply_and_check(mk(0, 9'h043, 5'd5, 5'd9, 5'd13), 3'd2, 1);      // R7 illegal path skips check, R11 upper
    apply_and_check(mk(0, 9'h029, 5'd31, 5'd0, 5'd3), 3'd5, 0);      // R4 sqrt single follows ftt
    apply_and_check(mk(0, 9'h02a, 5'd1, 5'd0, 5'd7), 3'd0, 0);       // R4 sqrt double
    apply_and_check(mk(1, 9'h057, 5'd3, 5'd0, 5'd4), 3'd3, 0);       // R10 compare
    apply_and_check(mk(1, 9'h053, 5'd0, 5'd2, 5'd4), 3'd3, 0);       // R10 compare bad rs1
    apply_and_check(mk(0, 9'h1ff, 5'd1, 5'd2, 5'd3), 3'd3, 0);       // R9 unimpl
    apply_and_check(mk(1, 9'h041, 5'd1, 5'd2, 5'd3), 3'd2, 0);       // R9 unimpl in second group
    apply_and_check(32'h41A0_0860, 3'd3, 0);                         // R2 wrong top bits
    apply_and_check(32'h81B0_0860, 3'd4, 0);                         // R2 wrong op3
    // random
    for (int n = 0; n < 600; n++) begin
      logic [31:0] w;
      logic [2:0] f;
      logic [10:0] c;
      int k;
      k = $urandom_range(0, 15);
      if (k == 0) w = $urandom;
      else if (k == 1) w = mk($urandom_range(0, 1), 9'($urandom), 5'($urandom), 5'($urandom), 5'($urandom));
      else w = mk(0, ops[$urandom_range(0, 29)], 5'($urandom), 5'($urandom), 5'($urandom));
      if (k == 2) w[24:19] = 6'h35;
      c = ref_cls(w[24:19] == 6'h35, w[13:5]);
      f = ($urandom_range(0, 3) != 0) ? c[2:0] : 3'($urandom);
      apply_and_check(w, f, $urandom_range(0, 3) == 0);
    end
    @(negedge clk);
    check(out_valid == 0, "R1 drop", out_valid, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule